// File: doc/BRIEF.md
# Byte-Sequenced Arithmetic Unit

This block is an arithmetic helper for an 8-bit processor bus. Software reaches it through a small register window: two operand ports (`A` and `B`), a port with no place in any operation (`X`), a shift-amount register (`CNT`), a mode register (`MODE`) and a control/busy register (`CTL`). There is no opcode. The unit works out which operation to run from the order in which bytes arrive at the `A` and `B` ports. It then computes one bit per clock while `busy` is high. Software collects the result a byte at a time, most significant byte first.

The sequencing state machine has these states. `ST_IDLE`. `ST_A1`, `ST_A2`, `ST_A3` and `ST_A4` count `A` writes. `ST_A2B1` and `ST_A4B1` mean one divisor byte has arrived after two or four `A` bytes. `ST_B1` and `ST_B2` count multiplier bytes. `ST_B2A1` means one multiplicand byte has arrived. `ST_RUN` is the busy window, `ST_DRAIN` is the result read-out, and `ST_FAULT` is the sticky error state.

The transitions work as follows:
- A write to `A` or `B` moves the machine one step along its load path.
- The closing write of a pattern enters `ST_RUN` and starts the engine. That write is the second `B` byte after two or four `A` bytes, the second `A` byte after two `B` bytes, or a `CNT` write in `ST_A4`.
- When the busy counter expires, the machine enters `ST_DRAIN`. The last expected result read returns it to `ST_IDLE`.
- Any access to `A`, `B` or `X` that does not fit the current state goes to `ST_FAULT`.
- Writing `CTL` with bit 0 clear returns the machine to `ST_IDLE` from every state.

Top module: `arith_seq_unit`

## Requirements
- R1: After reset, `busy` is 0 and reads of `CNT` (select 3), `MODE` (select 4) and `CTL` (select 5) return 0. The select codes are `A`=0, `B`=1, `X`=2.
- R2: 32/16 divide runs as follows:
  - Load: four `A` writes (dividend, LSB first), then two `B` writes (divisor, LSB first).
  - Results: four `A` reads return the quotient MSB first, then two `B` reads return the 16-bit remainder MSB first.
- R3: 16/16 divide runs as follows:
  - Load: two `A` writes (dividend, LSB first), then two `B` writes (divisor, LSB first).
  - Results: two `A` reads return the 16-bit quotient MSB first, then two `B` reads return the remainder MSB first.
- R4: Multiply runs as follows:
  - Load: two `B` writes (multiplier, LSB first), then two `A` writes (multiplicand, LSB first).
  - Results: four `A` reads return the 32-bit product MSB first.
- R5: Shift runs as follows:
  - Load: four `A` writes (LSB first), then a `CNT` write with a non-zero amount in bits [4:0].
  - Direction: `MODE` bit 0 selects it, 1 for right and 0 for left.
  - Results: four `A` reads return the shifted word MSB first, with vacated bits zero.
- R6: A `CNT` write of 0 in that position requests normalize:
  - The word is shifted left until bit 31 is 1. Four `A` reads return the mantissa.
  - `CNT` bits [4:0] then read as the number of positions shifted.
  - An input of zero gives mantissa 0 and count 0.
- R7: `busy` rises on the clock edge that takes the closing write. It stays high for exactly 36 clocks for 32/16 divide, shift and normalize, and for exactly 24 clocks for 16/16 divide and multiply.
- R8: A zero divisor finishes in the normal time with these results:
  - The quotient is all ones for its width and the remainder is the low 16 bits of the dividend.
  - `MODE` bit 7 reads 1.
  - Bit 7 reads 0 after any later operation with a non-zero divisor or of another kind.
- R9: A read or write of `A`, `B` or `X` out of sequence moves the unit to a fault state. It does so in any state: idle, loading, running or reading results. In the fault state `busy` stays at 1 until software clears it.
- R10: A `CTL` write with bit 0 = 0 makes `busy` 0 on the next clock and returns the unit to idle.
  - This works from every state, after which a new sequence runs normally.
  - If the clear lands on the last busy clock, the result is discarded and `CNT` is not overwritten with an exponent.
- R11: Accesses to `CNT`, `MODE` and `CTL` that sit between sequenced accesses do not disturb the operation. The exception is the `CNT` write that closes a shift pattern, and a `CTL` write with bit 0 = 0 clears the unit as R10 states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select: 0 A, 1 B, 2 X, 3 CNT, 4 MODE, 5 CTL |
| wr_en | input | 1 | Write strobe for the selected register, one access per clock |
| rd_en | input | 1 | Read strobe; a read of A or B pops one result byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, valid in the same cycle |
| busy | output | 1 | High while computing or while faulted |

## Verification
Two events can fall on the same clock edge: the software clear and the natural expiry of the busy counter, which would load the result and the normalize exponent. The bench starts a normalize of the value 1, which needs 31 shifts. It waits exactly 35 edges after the closing `CNT` write, checks that `busy` is still high, and places the `CTL` clear on the 36th edge. The unit passes if `busy` is low on the next clock and `CNT` still reads the 0 that started the operation rather than 31. A clear in the middle of a run is checked as well.

// File: rtl/arith_seq_pkg.sv
package arith_seq_pkg;

    localparam logic [2:0] SEL_A    = 3'd0;
    localparam logic [2:0] SEL_B    = 3'd1;
    localparam logic [2:0] SEL_X    = 3'd2;
    localparam logic [2:0] SEL_CNT  = 3'd3;
    localparam logic [2:0] SEL_MODE = 3'd4;
    localparam logic [2:0] SEL_CTL  = 3'd5;

    typedef enum logic [1:0] {
        OP_DIV32,
        OP_DIV16,
        OP_MUL,
        OP_SHIFT
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A1,
        ST_A2,
        ST_A3,
        ST_A4,
        ST_A2B1,
        ST_A4B1,
        ST_B1,
        ST_B2,
        ST_B2A1,
        ST_RUN,
        ST_DRAIN,
        ST_FAULT
    } state_e;

endpackage

// File: rtl/arith_seq_engine.sv
module arith_seq_engine
    import arith_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  op_e                    op,
    input  logic [DW-1:0]          opnd_a,
    input  logic [HW-1:0]          opnd_b,
    input  logic                   shr,
    input  logic [$clog2(DW)-1:0]  amount,
    output logic [DW-1:0]          result,
    output logic [HW-1:0]          remainder,
    output logic [$clog2(DW)-1:0]  expo,
    output logic                   active,
    output logic                   norm_mode
);

    localparam int EW = $clog2(DW);
    localparam int IW = $clog2(DW + 1);

    op_e           kind;
    logic [DW-1:0] acc;
    logic [HW-1:0] rem;
    logic [HW-1:0] dvs;
    logic [IW-1:0] left;
    logic          dir_r;

    // restoring division step
    logic [HW:0] trial;
    logic [HW:0] diff;
    logic        ge;
    // shift-add multiply step
    logic [HW:0] psum;

    always_comb begin
        trial = {rem, acc[DW-1]};
        ge    = trial >= {1'b0, dvs};
        diff  = trial - {1'b0, dvs};
        psum  = {1'b0, acc[DW-1:HW]} + (acc[0] ? {1'b0, dvs} : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind      <= OP_DIV32;
            acc       <= '0;
            rem       <= '0;
            dvs       <= '0;
            left      <= '0;
            dir_r     <= 1'b0;
            norm_mode <= 1'b0;
            expo      <= '0;
        end else if (start) begin
            kind      <= op;
            rem       <= '0;
            norm_mode <= 1'b0;
            expo      <= '0;
            dir_r     <= shr;
            unique case (op)
                OP_DIV32: begin
                    acc  <= opnd_a;
                    dvs  <= opnd_b;
                    left <= IW'(DW);
                end
                OP_DIV16: begin
                    acc  <= {opnd_a[DW-1:HW], {HW{1'b0}}};
                    dvs  <= opnd_b;
                    left <= IW'(HW);
                end
                OP_MUL: begin
                    acc  <= {{HW{1'b0}}, opnd_b};
                    dvs  <= opnd_a[DW-1:HW];
                    left <= IW'(HW);
                end
                OP_SHIFT: begin
                    acc <= opnd_a;
                    if (amount == '0) begin
                        norm_mode <= 1'b1;
                        left      <= IW'(DW - 1);
                    end else begin
                        left <= IW'(amount);
                    end
                end
                default: left <= '0;
            endcase
        end else if (left != '0) begin
            unique case (kind)
                OP_DIV32, OP_DIV16: begin
                    rem  <= ge ? diff[HW-1:0] : trial[HW-1:0];
                    acc  <= {acc[DW-2:0], ge};
                    left <= left - 1'b1;
                end
                OP_MUL: begin
                    acc  <= {psum, acc[HW-1:1]};
                    left <= left - 1'b1;
                end
                OP_SHIFT: begin
                    if (norm_mode) begin
                        if (acc[DW-1] || acc == '0) begin
                            left <= '0;
                        end else begin
                            acc  <= {acc[DW-2:0], 1'b0};
                            expo <= expo + 1'b1;
                            left <= left - 1'b1;
                        end
                    end else begin
                        acc  <= dir_r ? {1'b0, acc[DW-1:1]} : {acc[DW-2:0], 1'b0};
                        left <= left - 1'b1;
                    end
                end
                default: left <= '0;
            endcase
        end
    end

    assign result    = acc;
    assign remainder = rem;
    assign active    = (left != '0);

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (kind == OP_DIV32 || kind == OP_DIV16) && dvs != '0) |-> (rem < dvs)); // R2

    AST_NORM_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_mode && !active && acc != '0) |-> acc[DW-1]); // R6

    // EW is used for port widths; keep the localparam referenced.
    logic [EW-1:0] unused_ew;
    assign unused_ew = '0;

endmodule

// File: rtl/arith_seq_ctrl.sv
module arith_seq_ctrl
    import arith_seq_pkg::*;
#(
    parameter int CYC_LONG  = 36,
    parameter int CYC_SHORT = 24,
    parameter int NB        = 4,
    parameter int HB        = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 sel,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic                       wbit0,
    output logic                       busy,
    output logic                       start,
    output op_e                        start_op,
    output logic                       finish,
    output logic                       clr,
    output logic                       in_drain,
    output logic [$clog2(NB+1)-1:0]    a_left,
    output logic [$clog2(HB+1)-1:0]    b_left
);

    localparam int CW = $clog2(CYC_LONG + 1);

    state_e          state, nxt;
    op_e             cur_op;
    logic [CW-1:0]   run_cnt;

    logic wr_a, wr_b, rd_a, rd_b, wr_cnt, seq_acc, rd_a_ok, rd_b_ok;

    always_comb begin
        wr_a    = wr_en && sel == SEL_A;
        wr_b    = wr_en && sel == SEL_B;
        rd_a    = rd_en && sel == SEL_A;
        rd_b    = rd_en && sel == SEL_B;
        wr_cnt  = wr_en && sel == SEL_CNT;
        seq_acc = (wr_en || rd_en) && (sel == SEL_A || sel == SEL_B || sel == SEL_X);
        clr     = wr_en && sel == SEL_CTL && !wbit0;
        rd_a_ok = rd_a && a_left != '0;
        rd_b_ok = rd_b && a_left == '0 && b_left != '0;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (clr) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (wr_a) nxt = ST_A1; else if (wr_b) nxt = ST_B1;
                          else if (seq_acc) nxt = ST_FAULT;
                ST_A1:    if (wr_a) nxt = ST_A2; else if (seq_acc) nxt = ST_FAULT;
                ST_A2:    if (wr_a) nxt = ST_A3; else if (wr_b) nxt = ST_A2B1;
                          else if (seq_acc) nxt = ST_FAULT;
                ST_A3:    if (wr_a) nxt = ST_A4; else if (seq_acc) nxt = ST_FAULT;
                ST_A4:    if (wr_b) nxt = ST_A4B1; else if (wr_cnt) nxt = ST_RUN;
                          else if (seq_acc) nxt = ST_FAULT;
                ST_A2B1:  if (wr_b) nxt = ST_RUN; else if (seq_acc) nxt = ST_FAULT;
                ST_A4B1:  if (wr_b) nxt = ST_RUN; else if (seq_acc) nxt = ST_FAULT;
                ST_B1:    if (wr_b) nxt = ST_B2; else if (seq_acc) nxt = ST_FAULT;
                ST_B2:    if (wr_a) nxt = ST_B2A1; else if (seq_acc) nxt = ST_FAULT;
                ST_B2A1:  if (wr_a) nxt = ST_RUN; else if (seq_acc) nxt = ST_FAULT;
                ST_RUN:   if (seq_acc) nxt = ST_FAULT;
                          else if (run_cnt == CW'(1)) nxt = ST_DRAIN;
                ST_DRAIN: begin
                    if (rd_a_ok) begin
                        if (a_left == 1 && b_left == '0) nxt = ST_IDLE;
                    end else if (rd_b_ok) begin
                        if (b_left == 1) nxt = ST_IDLE;
                    end else if (seq_acc) begin
                        nxt = ST_FAULT;
                    end
                end
                ST_FAULT: nxt = ST_FAULT;
                default:  nxt = ST_FAULT;
            endcase
        end
    end

    // outputs
    always_comb begin
        start    = 1'b0;
        start_op = OP_DIV32;
        if (!clr) begin
            unique case (state)
                ST_A4:   if (wr_cnt) begin start = 1'b1; start_op = OP_SHIFT; end
                ST_A4B1: if (wr_b)   begin start = 1'b1; start_op = OP_DIV32; end
                ST_A2B1: if (wr_b)   begin start = 1'b1; start_op = OP_DIV16; end
                ST_B2A1: if (wr_a)   begin start = 1'b1; start_op = OP_MUL;   end
                default: start = 1'b0;
            endcase
        end
        busy     = (state == ST_RUN) || (state == ST_FAULT);
        in_drain = (state == ST_DRAIN);
        finish   = (state == ST_RUN) && run_cnt == CW'(1) && !clr && !seq_acc;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_op  <= OP_DIV32;
            run_cnt <= '0;
            a_left  <= '0;
            b_left  <= '0;
        end else begin
            state <= nxt;
            if (start) begin
                cur_op  <= start_op;
                run_cnt <= (start_op == OP_DIV16 || start_op == OP_MUL) ?
                           CW'(CYC_SHORT) : CW'(CYC_LONG);
            end else if (state == ST_RUN && run_cnt != '0) begin
                run_cnt <= run_cnt - 1'b1;
            end
            if (clr) begin
                a_left <= '0;
                b_left <= '0;
            end else if (finish) begin
                a_left <= (cur_op == OP_DIV16) ? $bits(a_left)'(NB/2) : $bits(a_left)'(NB);
                b_left <= (cur_op == OP_DIV32 || cur_op == OP_DIV16) ? $bits(b_left)'(HB) : '0;
            end else if (state == ST_DRAIN && rd_a_ok) begin
                a_left <= a_left - 1'b1;
            end else if (state == ST_DRAIN && rd_b_ok) begin
                b_left <= b_left - 1'b1;
            end
        end
    end

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R7

    AST_CLEAR_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && state == ST_IDLE)); // R10

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && !clr) |=> (state == ST_FAULT && busy)); // R9

    AST_REMAINDER_AFTER_QUOTIENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && $past(state == ST_DRAIN) && b_left != $past(b_left))
            |-> ($past(a_left) == '0)); // R2

endmodule

// File: rtl/arith_seq_unit.sv
module arith_seq_unit
    import arith_seq_pkg::*;
#(
    parameter int DW        = 32,
    parameter int CYC_LONG  = 36,
    parameter int CYC_SHORT = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       busy
);

    localparam int HW = DW / 2;
    localparam int NB = DW / 8;
    localparam int HB = HW / 8;
    localparam int EW = $clog2(DW);

    logic [DW-1:0] a_buf, a_nxt;
    logic [HW-1:0] b_buf, b_nxt;
    logic [EW-1:0] cnt_r;
    logic          dir_r;
    logic          ovf_r;

    logic          start, finish, clr, in_drain;
    op_e           start_op;
    logic [$clog2(NB+1)-1:0] a_left;
    logic [$clog2(HB+1)-1:0] b_left;

    logic [DW-1:0] res;
    logic [HW-1:0] rem;
    logic [EW-1:0] expo;
    logic          eng_active, eng_norm;

    // operand staging: bytes arrive LSB first, shifted in from the top
    always_comb begin
        a_nxt = (wr_en && reg_sel == SEL_A) ? {wdata, a_buf[DW-1:8]} : a_buf;
        b_nxt = (wr_en && reg_sel == SEL_B) ? {wdata, b_buf[HW-1:8]} : b_buf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_buf <= '0;
            b_buf <= '0;
            cnt_r <= '0;
            dir_r <= 1'b0;
            ovf_r <= 1'b0;
        end else begin
            a_buf <= a_nxt;
            b_buf <= b_nxt;
            if (wr_en && reg_sel == SEL_MODE) dir_r <= wdata[0];
            if (finish && eng_norm)
                cnt_r <= expo;
            else if (wr_en && reg_sel == SEL_CNT)
                cnt_r <= wdata[EW-1:0];
            if (start)
                ovf_r <= (start_op == OP_DIV32 || start_op == OP_DIV16) && b_nxt == '0;
        end
    end

    arith_seq_ctrl #(
        .CYC_LONG (CYC_LONG),
        .CYC_SHORT(CYC_SHORT),
        .NB       (NB),
        .HB       (HB)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (reg_sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wbit0   (wdata[0]),
        .busy    (busy),
        .start   (start),
        .start_op(start_op),
        .finish  (finish),
        .clr     (clr),
        .in_drain(in_drain),
        .a_left  (a_left),
        .b_left  (b_left)
    );

    arith_seq_engine #(
        .DW(DW),
        .HW(HW)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (start_op),
        .opnd_a   (a_nxt),
        .opnd_b   (b_nxt),
        .shr      (dir_r),
        .amount   (wdata[EW-1:0]),
        .result   (res),
        .remainder(rem),
        .expo     (expo),
        .active   (eng_active),
        .norm_mode(eng_norm)
    );

    // read mux: result bytes leave MSB first
    always_comb begin
        rdata = '0;
        unique case (reg_sel)
            SEL_A:    if (in_drain && a_left != '0)
                          rdata = res[8*(int'(a_left)-1) +: 8];
            SEL_B:    if (in_drain && a_left == '0 && b_left != '0)
                          rdata = rem[8*(int'(b_left)-1) +: 8];
            SEL_CNT:  rdata = 8'(cnt_r);
            SEL_MODE: rdata = {ovf_r, 6'b0, dir_r};
            SEL_CTL:  rdata = {7'b0, busy};
            default:  rdata = '0;
        endcase
    end

    AST_ENGINE_DONE_AT_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> !eng_active); // R7

    AST_ZERO_DIVISOR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (start_op == OP_DIV32 || start_op == OP_DIV16) && b_nxt == '0) |=> ovf_r); // R8

endmodule

// File: tb/test_arith_seq_unit.sv
module test_arith_seq_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    arith_seq_unit i_arith_seq_unit (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    localparam logic [2:0] A = 3'd0, B = 3'd1, X = 3'd2, CNT = 3'd3, MODE = 3'd4, CTL = 3'd5;

    typedef struct packed {
        logic [2:0]  kind;   // 0 div32, 1 div16, 2 mul, 3 shift, 4 normalize
        logic [31:0] a;
        logic [15:0] b;
        logic        dir;
        logic [4:0]  cnt;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h12345678, 16'h0123, 1'b0, 5'd0},
        '{3'd0, 32'hFFFFFFFF, 16'hFFFF, 1'b0, 5'd0},
        '{3'd0, 32'h00000005, 16'h0007, 1'b0, 5'd0},
        '{3'd1, 32'h0000BEEF, 16'h0011, 1'b0, 5'd0},
        '{3'd1, 32'h0000FFFF, 16'h0001, 1'b0, 5'd0},
        '{3'd2, 32'h0000FFFF, 16'hFFFF, 1'b0, 5'd0},
        '{3'd2, 32'h00001234, 16'hABCD, 1'b0, 5'd0},
        '{3'd3, 32'h80000001, 16'h0000, 1'b0, 5'd1},
        '{3'd3, 32'hF0000000, 16'h0000, 1'b1, 5'd31},
        '{3'd3, 32'h00FF00FF, 16'h0000, 1'b0, 5'd12},
        '{3'd3, 32'hDEADBEEF, 16'h0000, 1'b1, 5'd4},
        '{3'd4, 32'h00001234, 16'h0000, 1'b0, 5'd0},
        '{3'd4, 32'h80000000, 16'h0000, 1'b0, 5'd0},
        '{3'd4, 32'h00000001, 16'h0000, 1'b0, 5'd0},
        '{3'd4, 32'h00000000, 16'h0000, 1'b0, 5'd0},
        '{3'd0, 32'hCAFEBABE, 16'h0000, 1'b0, 5'd0},
        '{3'd1, 32'h00001234, 16'h0000, 1'b0, 5'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s; rd_en = 1'b1;
        #2 d = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic busy_now(output logic b);
        @(negedge clk);
        #1 b = busy;
    endtask

    function automatic logic [36:0] norm_ref(input logic [31:0] x);
        logic [31:0] m = x;
        int e = 0;
        if (m != 0) while (!m[31]) begin m = m << 1; e++; end
        return {e[4:0], m};
    endfunction

    task automatic do_op(input vec_t v);
        logic [7:0]  d;
        logic [31:0] got, exp_q;
        logic [15:0] got_r, exp_r;
        logic [36:0] nr;
        int cyc, exp_cyc, nread;
        string tag;
        case (v.kind)
            3'd0: begin
                wr(A, v.a[7:0]);
                wr(CNT, 8'd3);             // R11 interleaved non-trigger CNT write
                rd(MODE, d);               // R11 interleaved read
                wr(A, v.a[15:8]); wr(A, v.a[23:16]); wr(A, v.a[31:24]);
                wr(CTL, 8'h01);            // R11 CTL write with bit0 set
                wr(B, v.b[7:0]); wr(B, v.b[15:8]);
            end
            3'd1: begin
                wr(A, v.a[7:0]); wr(A, v.a[15:8]);
                wr(MODE, 8'h01);           // R11
                wr(B, v.b[7:0]); wr(B, v.b[15:8]);
            end
            3'd2: begin
                wr(B, v.b[7:0]); wr(B, v.b[15:8]);
                rd(CTL, d);                // R11
                wr(A, v.a[7:0]); wr(A, v.a[15:8]);
            end
            default: begin
                wr(MODE, {7'b0, v.dir});
                wr(A, v.a[7:0]); wr(A, v.a[15:8]); wr(A, v.a[23:16]); wr(A, v.a[31:24]);
                wr(CNT, (v.kind == 3'd4) ? 8'd0 : {3'b0, v.cnt});
            end
        endcase
        cyc = 0;
        forever begin
            @(negedge clk);
            #1 if (!busy) break;
            cyc++;
            if (cyc > 100) break;
        end
        exp_cyc = (v.kind == 3'd1 || v.kind == 3'd2) ? 24 : 36;
        check("R7 busy length", cyc, exp_cyc);

        nread = (v.kind == 3'd1) ? 2 : 4;
        got = '0;
        for (int i = 0; i < nread; i++) begin
            rd(A, d);
            got = {got[23:0], d};
        end
        got_r = '0;
        if (v.kind <= 3'd1) begin
            for (int i = 0; i < 2; i++) begin
                rd(B, d);
                got_r = {got_r[7:0], d};
            end
        end

        case (v.kind)
            3'd0, 3'd1: begin
                logic [31:0] dividend;
                dividend = (v.kind == 3'd1) ? {16'h0, v.a[15:0]} : v.a;
                if (v.b == 16'h0) begin
                    exp_q = (v.kind == 3'd1) ? 32'h0000FFFF : 32'hFFFFFFFF;
                    exp_r = dividend[15:0];
                    tag = "R8 zero divisor";
                end else begin
                    exp_q = dividend / {16'h0, v.b};
                    exp_r = 16'(dividend % {16'h0, v.b});
                    tag = (v.kind == 3'd1) ? "R3 div16" : "R2 R11 div32";
                end
                check({tag, " quotient"}, got, exp_q);
                check({tag, " remainder"}, {16'h0, got_r}, {16'h0, exp_r});
            end
            3'd2: check("R4 product", got, {16'h0, v.a[15:0]} * {16'h0, v.b});
            3'd3: check("R5 shift", got, v.dir ? (v.a >> v.cnt) : (v.a << v.cnt));
            default: begin
                nr = norm_ref(v.a);
                check("R6 mantissa", got, nr[31:0]);
                rd(CNT, d);
                check("R6 exponent", {24'h0, d}, {27'h0, nr[36:32]});
            end
        endcase
        rd(MODE, d);
        check("R8 overflow flag", {31'h0, d[7]}, {31'h0, (v.kind <= 3'd1 && v.b == 16'h0)});
        check("R2 R9 busy low after drain", {31'h0, busy}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic b;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        busy_now(b);
        check("R1 busy after reset", {31'h0, b}, 32'h0);
        rd(CNT, d);  check("R1 CNT after reset", {24'h0, d}, 32'h0);
        rd(MODE, d); check("R1 MODE after reset", {24'h0, d}, 32'h0);
        rd(CTL, d);  check("R1 CTL after reset", {24'h0, d}, 32'h0);

        for (int i = 0; i < NV; i++) do_op(VECS[i]);

        // R9 fault while loading: X access
        wr(A, 8'h11);
        rd(X, d);
        repeat (60) @(posedge clk);
        busy_now(b);
        check("R9 fault during load holds busy", {31'h0, b}, 32'h1);
        rd(CTL, d);
        check("R9 CTL shows busy in fault", {24'h0, d}, 32'h1);
        wr(CTL, 8'h00);
        busy_now(b);
        check("R10 clear from fault", {31'h0, b}, 32'h0);
        do_op('{3'd2, 32'h00000003, 16'h0005, 1'b0, 5'd0}); // R10 recovery

        // R9 fault while running
        wr(A, 8'h40); wr(A, 8'h00); wr(B, 8'h02); wr(B, 8'h00);
        repeat (5) @(posedge clk);
        wr(A, 8'h00);
        repeat (60) @(posedge clk);
        busy_now(b);
        check("R9 fault during run holds busy", {31'h0, b}, 32'h1);
        wr(CTL, 8'h00);

        // R9 fault on wrong read order: remainder before quotient
        wr(A, 8'h10); wr(A, 8'h00); wr(A, 8'h00); wr(A, 8'h00);
        wr(B, 8'h03); wr(B, 8'h00);
        repeat (40) @(posedge clk);
        busy_now(b);
        check("R7 div32 complete", {31'h0, b}, 32'h0);
        rd(B, d);
        busy_now(b);
        check("R9 fault on early remainder read", {31'h0, b}, 32'h1);
        wr(CTL, 8'h00);

        // R9 fault on read of A in idle
        rd(A, d);
        busy_now(b);
        check("R9 fault on idle read", {31'h0, b}, 32'h1);
        wr(CTL, 8'h00);

        // R10 clear mid-run
        wr(A, 8'h01); wr(A, 8'h00); wr(A, 8'h00); wr(A, 8'h00);
        wr(CNT, 8'h00);
        repeat (10) @(posedge clk);
        wr(CTL, 8'h00);
        busy_now(b);
        check("R10 clear mid-run", {31'h0, b}, 32'h0);

        // R10 clear on the final busy clock of a normalize
        wr(A, 8'h01); wr(A, 8'h00); wr(A, 8'h00); wr(A, 8'h00);
        wr(CNT, 8'h00);
        repeat (35) @(posedge clk);
        #1 check("R7 busy on last cycle", {31'h0, busy}, 32'h1);
        wr(CTL, 8'h00);
        busy_now(b);
        check("R10 clear coincides with finish", {31'h0, b}, 32'h0);
        rd(CNT, d);
        check("R10 exponent discarded", {24'h0, d}, 32'h0);
        do_op('{3'd4, 32'h00000100, 16'h0000, 1'b0, 5'd0}); // R10 next op normal

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule